// File: doc/BRIEF.md
# Single-Cycle Word Processor Core

This block is a 32-bit load/store processor that finishes one instruction in every clock cycle. Each cycle the program counter addresses an internal instruction memory. A decoder turns the fetched word into control signals. Two register operands are read, and an arithmetic unit produces either a result or a memory address. At the next rising edge the result is committed to the register file or the data memory, and the program counter moves to its next value. Nine operations are executed: add, sub, slt, and, or, lw, sw, beq and j. Every other encoding runs as a harmless no-operation.

Both memories are arrays inside the block. A loader port writes words into either memory. It is meant to be used while reset is held, so a program and its initial data can be placed before execution starts. The commit path is visible on the ports for observation: the program counter, the register write, and the memory store of the current instruction.

Top module: `sc_core_top`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 (asynchronously), and no register or memory write is signalled. After release, the first instruction is fetched from byte address 0.
- R2: An instruction that is neither a taken beq nor a j sets the next `pc_o` to the current `pc_o` + 4. `pc_o[1:0]` is always 00.
- R3: Register 0 always reads as zero. An instruction whose destination is register 0 does not assert `wb_en_o` and leaves register 0 unchanged.
- R4: add (opcode 0x00, funct 0x20) and sub (funct 0x22) write rs+rt and rs-rt, modulo 2^32, to rd. The R-type field positions are rs [25:21], rt [20:16], rd [15:11], shamt [10:6] (must be 0) and funct [5:0].
- R5: and (funct 0x24) and or (funct 0x25) write the bitwise result of rs and rt to rd.
- R6: slt (funct 0x2A) writes 1 to rd when rs < rt under signed comparison, and writes 0 otherwise.
- R7: lw (opcode 0x23) reads the data word at byte address rs + sign-extended imm[15:0] and writes it to rt [20:16]. The offset bit 15 is replicated into bits 31:16.
- R8: sw (opcode 0x2B) stores rt at byte address rs + sign-extended offset at the clock edge. It signals `dm_we_o` and asserts no register write.
- R9: beq (opcode 0x04) sets the next PC to PC+4 + (sign-extended offset << 2) when rs equals rt, and to PC+4 otherwise. It writes nothing.
- R10: j (opcode 0x02) sets the next PC to {PC+4[31:28], instr[25:0], 2'b00}.
- R11: Any other opcode, or an R-type word with another funct or a nonzero shamt, writes nothing and advances the PC by 4.
- R12: When `ld_we` is high, the loader writes `ld_data` at the clock edge to word `ld_addr` of the data memory (`ld_dmem`=1) or of the instruction memory (`ld_dmem`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ld_we | input | 1 | Loader write strobe |
| ld_dmem | input | 1 | Loader target: 1 = data memory, 0 = instruction memory |
| ld_addr | input | LOAD_AW (6) | Loader word index |
| ld_data | input | 32 | Loader write word |
| pc_o | output | 32 | Byte address of the instruction now executing |
| wb_en_o | output | 1 | A register write commits at the next edge |
| wb_addr_o | output | 5 | Destination register of that write |
| wb_data_o | output | 32 | Value being written |
| dm_we_o | output | 1 | A data store commits at the next edge |
| dm_addr_o | output | 32 | Byte address computed by the arithmetic unit |
| dm_wdata_o | output | 32 | Store data (rt operand) |

## Verification
On every cycle the assertions check how the program counter advances. They cover the +4 step, the branch target, the jump target and word alignment. They also check that a committed register write or data store is the value later held at that location. Only the bench's programs can show that each operation produces the right value. The same holds for the signed less-than decision, for the sign extension of negative offsets in real loads, for register 0 staying zero, and for no-operation handling of unknown encodings.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_LOAD = 6'h23;
  localparam logic [5:0] OPC_STOR = 6'h2B;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_JMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rt;
    logic    alu_imm;
    logic    mem_rd;
    logic    mem_we;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{reg_we: 1'b0, dst_rt: 1'b0, alu_imm: 1'b0, mem_rd: 1'b0,
             mem_we: 1'b0, branch: 1'b0, jump: 1'b0, alu_op: ALU_ADD};
    unique case (opcode)
      OPC_REG: begin
        if (shamt == 5'd0) begin
          ctrl.reg_we = 1'b1;
          unique case (funct)
            FN_ADD:  ctrl.alu_op = ALU_ADD;
            FN_SUB:  ctrl.alu_op = ALU_SUB;
            FN_AND:  ctrl.alu_op = ALU_AND;
            FN_OR:   ctrl.alu_op = ALU_OR;
            FN_SLT:  ctrl.alu_op = ALU_SLT;
            default: ctrl.reg_we = 1'b0;
          endcase
        end
      end
      OPC_LOAD: begin
        ctrl.reg_we  = 1'b1;
        ctrl.dst_rt  = 1'b1;
        ctrl.alu_imm = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OPC_STOR: begin
        ctrl.alu_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OPC_JMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG  = 32,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b
);

  logic [WIDTH-1:0] regs [NREG];
  logic             wr_en;

  // R3: entry 0 is never written and always reads as zero
  assign wr_en = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_en) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

  assert_rf_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            eq
);

  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign eq = (a == b);

endmodule

// File: rtl/sc_pc.sv
module sc_pc
  import sc_core_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            branch,
  input  logic            eq,
  input  logic            jump,
  input  logic [XLEN-1:0] offs,
  input  logic [25:0]     jfield,
  output logic [XLEN-1:0] pc
);

  logic [XLEN-1:0] pc_seq;
  logic [XLEN-1:0] pc_br;
  logic [XLEN-1:0] pc_nxt;
  logic            take_br;

  always_comb begin
    pc_seq  = pc + 32'd4;
    pc_br   = pc_seq + {offs[XLEN-3:0], 2'b00};
    take_br = branch && eq;
    if (jump)         pc_nxt = {pc_seq[31:28], jfield, 2'b00};
    else if (take_br) pc_nxt = pc_br;
    else              pc_nxt = pc_seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_nxt;
  end

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump && !(branch && eq)) |=> pc == $past(pc) + 32'd4);

  assert_pc_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (branch && eq && !jump) |=> pc == $past(pc) + 32'd4 + ($past(offs) << 2));

  assert_pc_jump_R10: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> (pc[27:0] == {$past(jfield), 2'b00}) &&
             (pc[31:28] == $past(pc[31:28] + {3'b000, (pc[27:2] == 26'h3FFFFFF)})));

endmodule

// File: rtl/sc_core_top.sv
module sc_core_top
  import sc_core_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  localparam int LOAD_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_we,
  input  logic               ld_dmem,
  input  logic [LOAD_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]    ld_data,
  output logic [XLEN-1:0]    pc_o,
  output logic               wb_en_o,
  output logic [4:0]         wb_addr_o,
  output logic [XLEN-1:0]    wb_data_o,
  output logic               dm_we_o,
  output logic [XLEN-1:0]    dm_addr_o,
  output logic [XLEN-1:0]    dm_wdata_o
);

  localparam int IDEPTH = 1 << IMEM_AW;
  localparam int DDEPTH = 1 << DMEM_AW;

  logic [XLEN-1:0] imem [IDEPTH];
  logic [XLEN-1:0] dmem [DDEPTH];

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] instr;
  ctrl_t           ctrl;
  logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, ld_word, wb_val;
  logic            alu_eq;
  logic [4:0]      dst;
  logic            rf_we, st_we;
  logic [DMEM_AW-1:0] d_idx;

  // instruction fetch, word addressed
  assign instr = imem[pc[IMEM_AW+1:2]];

  always_ff @(posedge clk) begin
    if (ld_we && !ld_dmem) imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
  end

  sc_decode u_dec (
    .opcode (instr[31:26]),
    .shamt  (instr[10:6]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  assign imm_ext = sext16(instr[15:0]);
  assign dst     = ctrl.dst_rt ? instr[20:16] : instr[15:11];
  assign rf_we   = ctrl.reg_we && rst_n;
  assign st_we   = ctrl.mem_we && rst_n;

  sc_regfile #(.NREG(32), .WIDTH(XLEN)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (dst),
    .wdata   (wb_val),
    .raddr_a (instr[25:21]),
    .raddr_b (instr[20:16]),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign alu_b = ctrl.alu_imm ? imm_ext : rt_val;

  sc_alu u_alu (
    .op (ctrl.alu_op),
    .a  (rs_val),
    .b  (alu_b),
    .y  (alu_y),
    .eq (alu_eq)
  );

  // data memory: loader has priority over a store
  assign d_idx   = alu_y[DMEM_AW+1:2];
  assign ld_word = dmem[d_idx];

  always_ff @(posedge clk) begin
    if (ld_we && ld_dmem) dmem[ld_addr[DMEM_AW-1:0]] <= ld_data;
    else if (st_we)       dmem[d_idx] <= rt_val;
  end

  assign wb_val = ctrl.mem_rd ? ld_word : alu_y;

  sc_pc u_pc (
    .clk    (clk),
    .rst_n  (rst_n),
    .branch (ctrl.branch),
    .eq     (alu_eq),
    .jump   (ctrl.jump),
    .offs   (imm_ext),
    .jfield (instr[25:0]),
    .pc     (pc)
  );

  assign pc_o       = pc;
  assign wb_en_o    = rf_we && (dst != 5'd0);
  assign wb_addr_o  = dst;
  assign wb_data_o  = wb_val;
  assign dm_we_o    = st_we;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

  assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);

  assert_store_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && !ld_we) |=> dmem[$past(d_idx)] == $past(rt_val));

  assert_one_action_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.reg_we, ctrl.mem_we, ctrl.branch, ctrl.jump}));

endmodule

// File: tb/test_sc_core_top.sv
module test_sc_core_top;

  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] ins;
    logic        we;
    logic [4:0]  rd;
    logic [31:0] wd;
    logic        dwe;
    logic [31:0] dad;
  } step_t;

  function automatic logic [31:0] rt_op(input logic [5:0] fn, input logic [4:0] d,
                                        input logic [4:0] s, input logic [4:0] t);
    return {6'h00, s, t, d, 5'd0, fn};
  endfunction
  function automatic logic [31:0] it_op(input logic [5:0] op, input logic [4:0] t,
                                        input logic [4:0] s, input logic [15:0] im);
    return {op, s, t, im};
  endfunction
  function automatic step_t st(input logic [7:0] a, input logic [31:0] i, input logic w,
                               input logic [4:0] r, input logic [31:0] d, input logic dw,
                               input logic [31:0] da);
    return '{wa: a, ins: i, we: w, rd: r, wd: d, dwe: dw, dad: da};
  endfunction

  localparam int NSTEP = 26;
  localparam step_t TRACE [NSTEP] = '{
    st(0,  it_op(6'h23, 1, 0, 16'd0),  1, 1,  32'd5,        0, 0),   // R7
    st(1,  it_op(6'h23, 2, 0, 16'd4),  1, 2,  32'd7,        0, 0),
    st(2,  it_op(6'h23, 3, 0, 16'd8),  1, 3,  32'hFFFFFFF0, 0, 0),
    st(3,  rt_op(6'h20, 4, 1, 2),      1, 4,  32'd12,       0, 0),   // R4 add
    st(4,  rt_op(6'h22, 5, 1, 2),      1, 5,  32'hFFFFFFFE, 0, 0),   // R4 sub
    st(5,  rt_op(6'h25, 6, 1, 3),      1, 6,  32'hFFFFFFF5, 0, 0),   // R5 or
    st(6,  rt_op(6'h24, 7, 2, 1),      1, 7,  32'd5,        0, 0),   // R5 and
    st(7,  rt_op(6'h2A, 8, 3, 1),      1, 8,  32'd1,        0, 0),   // R6
    st(8,  rt_op(6'h2A, 9, 1, 3),      1, 9,  32'd0,        0, 0),   // R6
    st(9,  it_op(6'h23, 10, 0, 16'd12),1, 10, 32'h80000000, 0, 0),
    st(10, rt_op(6'h2A, 11, 10, 1),    1, 11, 32'd1,        0, 0),   // R6 signed
    st(11, rt_op(6'h20, 12, 10, 10),   1, 12, 32'd0,        0, 0),   // R4 wrap
    st(12, rt_op(6'h20, 0, 1, 2),      0, 0,  32'd0,        0, 0),   // R3
    st(13, rt_op(6'h20, 13, 0, 1),     1, 13, 32'd5,        0, 0),   // R3
    st(14, it_op(6'h2B, 4, 0, 16'd16), 0, 0,  32'd12,       1, 16),  // R8
    st(15, it_op(6'h23, 14, 0, 16'd16),1, 14, 32'd12,       0, 0),   // R8
    st(16, it_op(6'h23, 15, 4, 16'hFFFC),1, 15, 32'hFFFFFFF0, 0, 0), // R7 neg
    st(17, it_op(6'h04, 2, 1, 16'd5),  0, 0,  32'd0,        0, 0),   // R9 not
    st(18, it_op(6'h04, 13, 1, 16'd3), 0, 0,  32'd0,        0, 0),   // R9 taken
    st(22, {6'h02, 26'd30},            0, 0,  32'd0,        0, 0),   // R10
    st(30, {6'h3F, 5'd0, 5'd5, 16'h1234}, 0, 0, 32'd0,      0, 0),   // R11
    st(31, rt_op(6'h00, 5, 1, 2),      0, 0,  32'd0,        0, 0),   // R11
    st(32, it_op(6'h04, 0, 0, 16'd7),  0, 0,  32'd0,        0, 0),   // R9
    st(40, rt_op(6'h20, 16, 5, 6),     1, 16, 32'hFFFFFFF3, 0, 0),   // R4
    st(41, it_op(6'h04, 0, 0, 16'hFFD6), 0, 0, 32'd0,       0, 0),   // R9 back
    st(0,  it_op(6'h23, 1, 0, 16'd0),  1, 1,  32'd5,        0, 0)
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_we, ld_dmem;
  logic [5:0]  ld_addr;
  logic [31:0] ld_data;
  logic [31:0] pc_o, wb_data_o, dm_addr_o, dm_wdata_o;
  logic        wb_en_o, dm_we_o;
  logic [4:0]  wb_addr_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sc_core_top i_sc_core_top (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .wb_en_o(wb_en_o),
    .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o), .dm_we_o(dm_we_o),
    .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load(input logic sel, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_dmem = sel; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ld_we = 1'b0; ld_dmem = 1'b0; ld_addr = '0; ld_data = '0;
    // R12: preload both memories while reset is held
    for (int w = 0; w < 64; w++) load(1'b0, 6'(w), 32'd0);
    for (int i = 0; i < NSTEP; i++) load(1'b0, TRACE[i].wa[5:0], TRACE[i].ins);
    load(1'b1, 6'd0, 32'd5);
    load(1'b1, 6'd1, 32'd7);
    load(1'b1, 6'd2, 32'hFFFFFFF0);
    load(1'b1, 6'd3, 32'h80000000);

    @(negedge clk);
    chk("R1 pc in reset", pc_o, 32'd0);
    chk("R1 no write in reset", {30'd0, wb_en_o, dm_we_o}, 32'd0);
    rst_n = 1'b1;

    // main vector walk, sampled mid-cycle
    for (int i = 0; i < NSTEP; i++) begin
      #1;
      chk("R2 pc", pc_o, {22'd0, TRACE[i].wa, 2'b00});
      chk("R3/R11 wb_en", {31'd0, wb_en_o}, {31'd0, TRACE[i].we});
      if (TRACE[i].we) begin
        chk("R4-7 wb addr", {27'd0, wb_addr_o}, {27'd0, TRACE[i].rd});
        chk("R4/R5/R6/R7 wb data", wb_data_o, TRACE[i].wd);
      end
      chk("R8 dm_we", {31'd0, dm_we_o}, {31'd0, TRACE[i].dwe});
      if (TRACE[i].dwe) begin
        chk("R8 store addr", dm_addr_o, TRACE[i].dad);
        chk("R8 store data", dm_wdata_o, TRACE[i].wd);
      end
      @(negedge clk);
    end

    // R1: asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async pc", pc_o, 32'd0);
    chk("R1 async no write", {31'd0, wb_en_o}, 32'd0);

    // R12 + R10: reload word 0 with a jump to word 50
    load(1'b0, 6'd0, {6'h02, 26'd50});
    load(1'b0, 6'd50, rt_op(6'h20, 18, 4, 1));
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R12 reloaded jump pc", pc_o, 32'd0);
    @(negedge clk); #1;
    chk("R10 jump target", pc_o, 32'd200);
    chk("R12 reloaded add wb", wb_data_o, 32'd17);
    chk("R12 reloaded add en", {31'd0, wb_en_o}, 32'd1);
    @(negedge clk); #1;
    chk("R11 zero word pc", pc_o, 32'd204);
    chk("R11 zero word no write", {30'd0, wb_en_o, dm_we_o}, 32'd0);
    @(negedge clk); #1;
    chk("R2 step after nop", pc_o, 32'd208);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule